// File: doc/BRIEF.md
# No-Turnaround Flow-Through Synchronous SRAM

This block is a cycle-accurate, synthesizable model of a single-port synchronous SRAM. Reads flow through: the word addressed at a clock edge is presented on the output in the cycle that follows that edge, with no extra output stage. Writes are late: the address and byte-lane enables are registered at one edge, and the data is taken at the next enabled edge. A read can therefore directly follow a write on the shared bus with no idle cycle. A read that hits the word still waiting for its late data returns that data, merged lane by lane with the stored word.

A four-beat burst starts with a load cycle. Each following continue cycle steps an internal 2-bit beat counter. The counter follows either a linear order (add) or an interleaved order (XOR), and it always stays inside the aligned four-word block. A clock-enable input freezes the whole block. Three chip selects, an asynchronous output enable and a snooze input complete the control set. Snooze has a short recovery window.

The data bus is modelled as separate input and output vectors plus a drive flag. Depth and lane width are parameters: a lane width of 8 gives a 32-bit word, and a lane width of 9 gives a 36-bit word.

Top module: `ntft_sram`

## Requirements
- R1: A load cycle (`adv_i`=0) with all chip selects active (`cs1_n_i`=0, `cs2_i`=1, `cs3_n_i`=0) and `we_n_i`=1 reads the word at `addr_i`. Just after that edge `drive_o`=1 and `rdata_o` holds the word, provided `oe_n_i`=0.
- R2: A load cycle with `we_n_i`=0 registers a write. Its data is taken from `wdata_i` at the next enabled edge. Lane l is bits [l*LANE_W +: LANE_W], and it is written only when `lane_we_n_i[l]`=0, the value sampled at the address edge.
- R3: A read of the address whose write data is taken at the same edge returns that new data in the enabled lanes and the stored data in the other lanes. No idle cycle is needed between them.
- R4: With `order_i`=0 at the load cycle, beat n of a burst accesses the address with its upper bits unchanged and its low two bits equal to (start + n) mod 4. This holds for both read and write bursts.
- R5: With `order_i`=1 at the load cycle, the low two bits of beat n are start XOR n.
- R6: On a continue cycle (`adv_i`=1), `addr_i` and `we_n_i` are ignored. The fifth beat wraps back to the start address and never carries into the upper address bits.
- R7: While `cke_n_i`=1, no state changes. The output data and drive hold, and a pending write waits to take its data at the next enabled edge.
- R8: A load cycle with any chip select inactive is a deselect: `drive_o`=0 afterwards. A continue cycle after a deselect stays deselected.
- R9: `oe_n_i`=1 forces `drive_o`=0 and `rdata_o`=0 at once, with no clock edge needed.
- R10: In the cycle after a write edge, `drive_o`=0.
- R11: An edge with `sleep_i`=1, and each of the WAKE_CYC (2) edges after `sleep_i` falls, acts as a deselect. At these edges all other inputs are ignored, the array is not written, and a pending write is held.
- R12: After reset `drive_o`=0 and no burst is in progress, so a continue cycle does not drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sleep_i | input | 1 | Snooze request, active high |
| cke_n_i | input | 1 | Clock enable, active low (1 = stall) |
| cs1_n_i | input | 1 | Chip select, active low |
| cs2_i | input | 1 | Chip select, active high |
| cs3_n_i | input | 1 | Chip select, active low |
| adv_i | input | 1 | 1 = continue burst, 0 = load new address |
| we_n_i | input | 1 | 0 = write, 1 = read (load cycles only) |
| order_i | input | 1 | Burst order: 1 = interleaved XOR, 0 = linear add |
| lane_we_n_i | input | LANES | Per-lane write enables, active low |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | LANES*LANE_W | Write data, one enabled edge after its address |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| rdata_o | output | LANES*LANE_W | Read data, zero when not driven |
| drive_o | output | 1 | High when the output would drive the bus |

## Verification
The properties assume that the clock enable, chip selects and snooze input are sampled only at rising edges. They also assume that reset is held for at least one edge before any command. Under these assumptions the internal write-pending, read-valid and burst-live flags have defined values from the first check onward. The bench changes every input one nanosecond after a rising edge and keeps it steady through the next edge. It starts snooze only after reset has been released, so the recovery counter and the quiet indication always line up. Write data follows each write address on the next enabled edge, as the late-write protocol requires.

// File: rtl/ntft_pkg.sv
package ntft_pkg;
  typedef enum logic [1:0] {OP_IDLE, OP_READ, OP_WRITE} op_e;

  // low two address bits of a burst beat
  function automatic logic [1:0] beat_lo(input logic [1:0] start,
                                         input logic [1:0] n,
                                         input logic ilv);
    return ilv ? (start ^ n) : (start + n);
  endfunction
endpackage

// File: rtl/ntft_burst.sv
module ntft_burst
  import ntft_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_i,
  input  logic              flush_i,
  input  logic              load_i,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic              order_i,
  input  logic [ADDR_W-1:0] addr_i,
  output op_e               op_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic              live_o
);
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        cnt_q;
  logic [1:0]        cnt_nxt;
  logic              live_q, we_q, ilv_q;

  assign cnt_nxt = cnt_q + 2'd1;
  assign live_o  = live_q;

  always_comb begin
    if (load_i) begin
      op_addr_o = addr_i;
      op_o      = !sel_i ? OP_IDLE : (we_i ? OP_WRITE : OP_READ);
    end else begin
      op_addr_o = {base_q[ADDR_W-1:2], beat_lo(base_q[1:0], cnt_nxt, ilv_q)};
      op_o      = !live_q ? OP_IDLE : (we_q ? OP_WRITE : OP_READ);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q <= 1'b0;
      cnt_q  <= 2'd0;
      base_q <= '0;
      we_q   <= 1'b0;
      ilv_q  <= 1'b0;
    end else if (flush_i) begin
      live_q <= 1'b0;
    end else if (step_i) begin
      if (load_i) begin
        live_q <= sel_i;
        base_q <= addr_i;
        cnt_q  <= 2'd0;
        we_q   <= we_i;
        ilv_q  <= order_i;
      end else if (live_q) begin
        cnt_q <= cnt_nxt;
      end
    end
  end
endmodule

// File: rtl/ntft_wpend.sv
module ntft_wpend #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_i,
  input  logic              set_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANES-1:0]  be_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LANES-1:0]  be_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
      be_o    <= '0;
    end else if (step_i) begin
      valid_o <= set_i;
      addr_o  <= addr_i;
      be_o    <= be_i;
    end
  end
endmodule

// File: rtl/ntft_array.sv
module ntft_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    we_i,
  input  logic [ADDR_W-1:0]       waddr_i,
  input  logic [LANES-1:0]        wbe_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  input  logic                    re_i,
  input  logic [ADDR_W-1:0]       raddr_i,
  output logic [LANES*LANE_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we_i && wbe_i[l]) mem[waddr_i] <= wdata_i[l*LANE_W +: LANE_W];
      if (re_i) rdata_o[l*LANE_W +: LANE_W] <= mem[raddr_i];
    end
  end
endmodule

// File: rtl/ntft_snooze.sv
module ntft_snooze #(
  parameter int WAKE_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sleep_i,
  output logic quiet_o
);
  localparam int CW = $clog2(WAKE_CYC + 1);
  logic [CW-1:0] rec_q;

  assign quiet_o = sleep_i || (rec_q != '0);

  always_ff @(posedge clk) begin
    if (rst)                rec_q <= '0;
    else if (sleep_i)       rec_q <= CW'(WAKE_CYC);
    else if (rec_q != '0)   rec_q <= rec_q - CW'(1);
  end
endmodule

// File: rtl/ntft_sram.sv
module ntft_sram
  import ntft_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int LANES    = 4,
  parameter int LANE_W   = 8,
  parameter int WAKE_CYC = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sleep_i,
  input  logic                    cke_n_i,
  input  logic                    cs1_n_i,
  input  logic                    cs2_i,
  input  logic                    cs3_n_i,
  input  logic                    adv_i,
  input  logic                    we_n_i,
  input  logic                    order_i,
  input  logic [LANES-1:0]        lane_we_n_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  input  logic                    oe_n_i,
  output logic [LANES*LANE_W-1:0] rdata_o,
  output logic                    drive_o
);
  localparam int DW = LANES * LANE_W;

  logic              quiet, active, chip_on, live;
  op_e               op;
  logic [ADDR_W-1:0] op_addr;
  logic              op_is_rd, op_is_wr;
  logic              pend_valid;
  logic [ADDR_W-1:0] pend_addr;
  logic [LANES-1:0]  pend_be;
  logic [DW-1:0]     arr_q;
  logic              rd_valid_q;
  logic [LANES-1:0]  byp_mask_q;
  logic [DW-1:0]     byp_data_q;
  logic [DW-1:0]     merged;

  assign chip_on  = !cs1_n_i && cs2_i && !cs3_n_i;
  assign active   = !quiet && !cke_n_i;
  assign op_is_rd = active && (op == OP_READ);
  assign op_is_wr = active && (op == OP_WRITE);

  ntft_snooze #(.WAKE_CYC(WAKE_CYC)) u_snooze (
    .clk(clk), .rst(rst), .sleep_i(sleep_i), .quiet_o(quiet)
  );

  ntft_burst #(.ADDR_W(ADDR_W)) u_burst (
    .clk(clk), .rst(rst), .step_i(active), .flush_i(quiet),
    .load_i(!adv_i), .sel_i(chip_on), .we_i(!we_n_i), .order_i(order_i),
    .addr_i(addr_i), .op_o(op), .op_addr_o(op_addr), .live_o(live)
  );

  ntft_wpend #(.ADDR_W(ADDR_W), .LANES(LANES)) u_wpend (
    .clk(clk), .rst(rst), .step_i(active), .set_i(op == OP_WRITE),
    .addr_i(op_addr), .be_i(~lane_we_n_i),
    .valid_o(pend_valid), .addr_o(pend_addr), .be_o(pend_be)
  );

  ntft_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk(clk), .we_i(active && pend_valid), .waddr_i(pend_addr),
    .wbe_i(pend_be), .wdata_i(wdata_i), .re_i(op_is_rd),
    .raddr_i(op_addr), .rdata_o(arr_q)
  );

  // read-valid flag and late-write bypass capture
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid_q <= 1'b0;
      byp_mask_q <= '0;
      byp_data_q <= '0;
    end else if (quiet) begin
      rd_valid_q <= 1'b0;
    end else if (active) begin
      rd_valid_q <= op_is_rd;
      if (op_is_rd) begin
        byp_mask_q <= (pend_valid && pend_addr == op_addr) ? pend_be : '0;
        byp_data_q <= wdata_i;
      end
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_merge
    assign merged[l*LANE_W +: LANE_W] = byp_mask_q[l] ? byp_data_q[l*LANE_W +: LANE_W]
                                                      : arr_q[l*LANE_W +: LANE_W];
  end

  assign drive_o = !oe_n_i && rd_valid_q;
  assign rdata_o = drive_o ? merged : '0;
endmodule

// File: rtl/ntft_sram_chk.sv
module ntft_sram_chk (
  input logic clk,
  input logic rst,
  input logic cke_n_i,
  input logic adv_i,
  input logic oe_n_i,
  input logic sleep_i,
  input logic chip_on,
  input logic quiet,
  input logic op_is_wr,
  input logic pend_valid,
  input logic rd_valid_q,
  input logic live,
  input logic drive_o
);
  p_stall_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!quiet && cke_n_i) |=> ($stable(pend_valid) && $stable(rd_valid_q) && $stable(live)));

  p_write_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    op_is_wr |=> !drive_o);

  p_deselect_r8: assert property (@(posedge clk) disable iff (rst)
    (!quiet && !cke_n_i && !adv_i && !chip_on) |=> (!drive_o && !live));

  p_snooze_idle_r11: assert property (@(posedge clk) disable iff (rst)
    quiet |=> !drive_o);

  p_recovery_r11: assert property (@(posedge clk) disable iff (rst)
    sleep_i |=> quiet);

  p_oe_off_r9: assert property (@(posedge clk) disable iff (rst)
    oe_n_i |-> !drive_o);

  p_late_data_r2: assert property (@(posedge clk) disable iff (rst)
    (!quiet && !cke_n_i && !op_is_wr) |=> !pend_valid);
endmodule

bind ntft_sram ntft_sram_chk u_chk (
  .clk(clk), .rst(rst), .cke_n_i(cke_n_i), .adv_i(adv_i), .oe_n_i(oe_n_i),
  .sleep_i(sleep_i), .chip_on(chip_on), .quiet(quiet), .op_is_wr(op_is_wr),
  .pend_valid(pend_valid), .rd_valid_q(rd_valid_q), .live(live), .drive_o(drive_o)
);

// File: tb/ntft_sram_tb_top.sv
module ntft_sram_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sleep_i = 1'b0, cke_n = 1'b0, cs1_n = 1'b0, cs2 = 1'b1, cs3_n = 1'b0;
  logic        adv = 1'b0, we_n = 1'b1, order = 1'b0, oe_n = 1'b0;
  logic [3:0]  lane_we_n = 4'hF;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        drive;
  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  ntft_sram dut_i (
    .clk(clk), .rst(rst), .sleep_i(sleep_i), .cke_n_i(cke_n), .cs1_n_i(cs1_n),
    .cs2_i(cs2), .cs3_n_i(cs3_n), .adv_i(adv), .we_n_i(we_n), .order_i(order),
    .lane_we_n_i(lane_we_n), .addr_i(addr), .wdata_i(wdata), .oe_n_i(oe_n),
    .rdata_o(rdata), .drive_o(drive)
  );

  function automatic logic [31:0] pat(input int a);
    return 32'hA500_0000 ^ (32'(a) * 32'h0103_0507);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic go(input logic a_adv, input logic a_wen, input logic [5:0] a_addr,
                    input logic [3:0] a_ben, input logic [31:0] a_wd);
    adv = a_adv; we_n = a_wen; addr = a_addr; lane_we_n = a_ben; wdata = a_wd;
    tick();
  endtask

  task automatic idle(input logic [31:0] a_wd);
    cs2 = 1'b0;
    go(1'b0, 1'b1, 6'd0, 4'hF, a_wd);
    cs2 = 1'b1;
  endtask

  task automatic rd(input int a);
    go(1'b0, 1'b1, 6'(a), 4'hF, 32'h0);
  endtask

  task automatic fill(input int base, input int n);
    logic [31:0] prev;
    prev = '0;
    for (int i = 0; i < n; i++) begin
      go(1'b0, 1'b0, 6'(base + i), 4'h0, prev);
      prev = pat(base + i);
    end
    idle(prev);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) tick();
    rst = 1'b0;
    chk("R12 drive after reset", {31'd0, drive}, 32'd0);
    go(1'b1, 1'b1, 6'd5, 4'hF, 32'h0);
    chk("R12 continue after reset", {31'd0, drive}, 32'd0);
  endtask

  task automatic t_read();
    fill(8, 4);
    rd(9);
    chk("R1 drive", {31'd0, drive}, 32'd1);
    chk("R1 data 9", rdata, pat(9));
    rd(8);
    chk("R1 data 8", rdata, pat(8));
  endtask

  task automatic t_lanes();
    fill(40, 1);
    go(1'b0, 1'b0, 6'd40, 4'b1010, 32'h0);
    chk("R10 no drive on write", {31'd0, drive}, 32'd0);
    idle(32'hAABB_CCDD);
    rd(40);
    chk("R2 lane merge", rdata, (pat(40) & 32'hFF00_FF00) | 32'h00BB_00DD);
  endtask

  task automatic t_raw();
    fill(12, 2);
    go(1'b0, 1'b0, 6'd12, 4'b1101, 32'h0);
    go(1'b0, 1'b1, 6'd12, 4'hF, 32'h1234_AB00);
    chk("R3 bypass partial", rdata, (pat(12) & 32'hFFFF_00FF) | 32'h0000_AB00);
    rd(12);
    chk("R3 committed", rdata, (pat(12) & 32'hFFFF_00FF) | 32'h0000_AB00);
    go(1'b0, 1'b0, 6'd13, 4'h0, 32'h0);
    go(1'b0, 1'b1, 6'd13, 4'hF, 32'h5566_7788);
    chk("R3 bypass full", rdata, 32'h5566_7788);
  endtask

  task automatic t_linear();
    fill(16, 4);
    order = 1'b0;
    rd(18);
    chk("R4 beat0", rdata, pat(18));
    go(1'b1, 1'b0, 6'd3, 4'h0, 32'h0);
    chk("R4 beat1", rdata, pat(19));
    go(1'b1, 1'b0, 6'd50, 4'h0, 32'h0);
    chk("R4 beat2", rdata, pat(16));
    go(1'b1, 1'b0, 6'd7, 4'h0, 32'h0);
    chk("R4 beat3", rdata, pat(17));
    go(1'b1, 1'b0, 6'd9, 4'h0, 32'h0);
    chk("R6 wrap", rdata, pat(18));
    rd(19);
    chk("R6 we_n ignored", rdata, pat(19));
    // linear write burst starting at 21
    go(1'b0, 1'b0, 6'd21, 4'h0, 32'h0);
    go(1'b1, 1'b1, 6'd60, 4'h0, 32'h1111_0021);
    go(1'b1, 1'b1, 6'd61, 4'h0, 32'h1111_0022);
    go(1'b1, 1'b1, 6'd62, 4'h0, 32'h1111_0023);
    idle(32'h1111_0020);
    rd(20);
    chk("R4 write burst wrap", rdata, 32'h1111_0020);
    rd(23);
    chk("R4 write burst beat2", rdata, 32'h1111_0023);
  endtask

  task automatic t_ilv();
    order = 1'b1;
    rd(17);
    order = 1'b0;
    chk("R5 beat0", rdata, pat(17));
    go(1'b1, 1'b1, 6'd0, 4'hF, 32'h0);
    chk("R5 beat1", rdata, pat(16));
    go(1'b1, 1'b1, 6'd0, 4'hF, 32'h0);
    chk("R5 beat2", rdata, pat(19));
    go(1'b1, 1'b1, 6'd0, 4'hF, 32'h0);
    chk("R5 beat3", rdata, pat(18));
  endtask

  task automatic t_stall();
    rd(16);
    cke_n = 1'b1;
    go(1'b0, 1'b1, 6'd30, 4'hF, 32'h0);
    go(1'b0, 1'b0, 6'd31, 4'h0, 32'h0);
    chk("R7 drive held", {31'd0, drive}, 32'd1);
    chk("R7 data held", rdata, pat(16));
    cke_n = 1'b0;
    go(1'b1, 1'b1, 6'd0, 4'hF, 32'h0);
    chk("R7 burst resumes", rdata, pat(17));
    go(1'b0, 1'b0, 6'd28, 4'h0, 32'h0);
    cke_n = 1'b1;
    go(1'b0, 1'b1, 6'd0, 4'hF, 32'hBAD0_BAD0);
    go(1'b0, 1'b1, 6'd0, 4'hF, 32'hBAD1_BAD1);
    cke_n = 1'b0;
    idle(32'hDEAD_1234);
    rd(28);
    chk("R7 late data after stall", rdata, 32'hDEAD_1234);
  endtask

  task automatic t_desel();
    rd(8);
    cs1_n = 1'b1;
    rd(9);
    cs1_n = 1'b0;
    chk("R8 cs1 deselect", {31'd0, drive}, 32'd0);
    go(1'b1, 1'b1, 6'd0, 4'hF, 32'h0);
    chk("R8 continue stays off", {31'd0, drive}, 32'd0);
    cs3_n = 1'b1;
    rd(9);
    cs3_n = 1'b0;
    chk("R8 cs3 deselect", {31'd0, drive}, 32'd0);
  endtask

  task automatic t_oe();
    rd(9);
    oe_n = 1'b1;
    #1;
    chk("R9 drive off", {31'd0, drive}, 32'd0);
    chk("R9 data zero", rdata, 32'd0);
    oe_n = 1'b0;
    #1;
    chk("R9 drive back", rdata, pat(9));
  endtask

  task automatic t_sleep();
    fill(25, 1);
    go(1'b0, 1'b0, 6'd24, 4'h0, 32'h0);
    sleep_i = 1'b1;
    go(1'b0, 1'b0, 6'd25, 4'h0, 32'hBAD2_BAD2);
    sleep_i = 1'b0;
    chk("R11 asleep", {31'd0, drive}, 32'd0);
    go(1'b0, 1'b1, 6'd24, 4'hF, 32'hBAD3_BAD3);
    chk("R11 recovery 1", {31'd0, drive}, 32'd0);
    go(1'b0, 1'b1, 6'd24, 4'hF, 32'hBAD4_BAD4);
    chk("R11 recovery 2", {31'd0, drive}, 32'd0);
    idle(32'hCAFE_0024);
    rd(24);
    chk("R11 pending held", rdata, 32'hCAFE_0024);
    rd(25);
    chk("R11 write ignored", rdata, pat(25));
  endtask

  initial begin
    #800000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    t_read();
    t_lanes();
    t_raw();
    t_linear();
    t_ilv();
    t_stall();
    t_desel();
    t_oe();
    t_sleep();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule